// File: doc/BRIEF.md
# Power-Controller Top-Level Interrupt Status Register

This block is the top-level interrupt status byte of a power-management controller. It watches six event sources: a power-good indicator, an external clock detector, thermal-warning and thermal-shutdown comparators, an input over-voltage comparator and a load-current-measurement-complete strobe. It latches each event into a sticky flag that software clears by writing 1 to it. Two further bits are read-only summaries that show whether the separate LDO and buck pending-interrupt bytes hold anything. The block drives one interrupt line toward the host.

The thermal-shutdown and over-voltage flags also act as a safety interlock. When either event latches, every regulator enable is dropped. The general-purpose outputs are held low for as long as either flag remains set. While the thermal-shutdown flag is set, new regulator enable requests are refused. The live, unlatched state of the three analog comparators is exported beside the flags. All asynchronous detector levels pass through a synchronizer before any edge is taken from them.

Top module: `pmic_irq_top`

## Requirements
- R1: After reset the register reads 0x00, `irq_o` is 0, all regulator enables are 0 and no GPO is forced low.
- R2: The register sits at bus address 0x19. Reads at any other address return 0x00, and writes at any other address change nothing.
- R3: Bits 7, 4, 3, 2, 1 and 0 are sticky. A register write with a 1 in a bit position clears that bit, and a 0 leaves it as it was.
- R4: If a bit's event and a write-1 clear of that bit fall in the same cycle, the bit ends up set.
- R5: Bit 7 latches when power-good (`pg_in`, 1 = good) goes from 1 to 0. A rise from 0 to 1 latches nothing.
- R6: Bit 4 latches on both a rise and a fall of the external clock-present level `ext_clk_det_in`.
- R7: Bits 3 (thermal shutdown), 2 (thermal warning) and 1 (over-voltage) latch on a rise of their comparator, and nothing latches on a fall. The `*_live_o` outputs follow each synchronized comparator level without latching.
- R8: Bit 6 is 1 exactly while `ldo_pend_i` is nonzero, and bit 5 is 1 exactly while `buck_pend_i` is nonzero. Writes have no effect on either bit.
- R9: `irq_o` equals the OR of all eight register bits as they stood one clock earlier.
- R10: In the cycle that bit 3 or bit 1 latches, all regulator enables drop to 0. `gpo_o` is 0 while bit 3 or bit 1 is set, and otherwise follows `gpo_req_i`.
- R11: While bit 3 is set, `reg_on_req_i` is ignored. Bit 1 set alone does not block enable requests.
- R12: Bit 0 latches in any cycle where `meas_done_i` is 1.
- R13: A level change on an asynchronous detector appears in `*_live_o` after the second rising clock edge and in its register flag after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pg_in | input | 1 | Power-good level, asynchronous, 1 = good |
| ext_clk_det_in | input | 1 | External clock present, asynchronous |
| tsd_in | input | 1 | Thermal shutdown comparator, asynchronous |
| twarn_in | input | 1 | Thermal warning comparator, asynchronous |
| ovp_in | input | 1 | Input over-voltage comparator, asynchronous |
| meas_done_i | input | 1 | Current measurement complete, synchronous |
| ldo_pend_i | input | 8 | LDO pending-interrupt byte |
| buck_pend_i | input | 8 | Buck pending-interrupt byte |
| reg_on_req_i | input | N_REG (4) | Per-regulator enable request pulses |
| reg_off_req_i | input | N_REG (4) | Per-regulator disable request pulses |
| gpo_req_i | input | N_GPO (2) | Requested GPO levels |
| reg_en_o | output | N_REG (4) | Regulator enables |
| gpo_o | output | N_GPO (2) | General-purpose outputs after interlock |
| irq_o | output | 1 | Combined interrupt, active high |
| tsd_live_o | output | 1 | Synchronized thermal-shutdown level |
| twarn_live_o | output | 1 | Synchronized thermal-warning level |
| ovp_live_o | output | 1 | Synchronized over-voltage level |

## Verification
The bench targets the edge polarity of each source. A power-good recovery must not latch, while both directions of the clock detector must latch. A design that took the wrong edge would raise a flag on recovery or miss one of the two clock transitions. The bench also makes a clear collide with a new event in the same cycle, where a design that let the clear win would lose the event. It writes zeros, writes to the summary bits and writes to a neighbouring address, which a careless write decode would let alter the byte. For the interlock, the bench checks that over-voltage drops the enables without blocking a later request, and that thermal shutdown refuses requests until its flag is cleared. A design that confused the two would either leave regulators locked out or let them come back during a shutdown.

// File: rtl/pmic_irq_pkg.sv
package pmic_irq_pkg;

  localparam int unsigned DW = 8;

  // register bit positions (software decodes these)
  localparam int unsigned B_PG    = 7;
  localparam int unsigned B_LDO   = 6;
  localparam int unsigned B_BUCK  = 5;
  localparam int unsigned B_CLK   = 4;
  localparam int unsigned B_TSD   = 3;
  localparam int unsigned B_TWARN = 2;
  localparam int unsigned B_OVP   = 1;
  localparam int unsigned B_MEAS  = 0;

  // sticky bits; the rest are summaries
  localparam logic [DW-1:0] STICKY_MASK = 8'b1001_1111;

  // index of each asynchronous detector in the synchronizer vector
  localparam int unsigned S_PG    = 0;
  localparam int unsigned S_CLK   = 1;
  localparam int unsigned S_TSD   = 2;
  localparam int unsigned S_TWARN = 3;
  localparam int unsigned S_OVP   = 4;
  localparam int unsigned N_DET   = 5;

endpackage

// File: rtl/pmic_irq_sync.sv
module pmic_irq_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];
  logic [W-1:0] prev_q;

  always_comb begin
    stg_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/pmic_irq_flags.sv
module pmic_irq_flags #(
  parameter int unsigned    W    = 8,
  parameter logic [W-1:0]   MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_sticky
      logic bit_q, bit_d, bit_en;
      // set dominates clear so a colliding event is kept
      assign bit_d  = set_i[i] | (bit_q & ~clr_i[i]);
      assign bit_en = set_i[i] | clr_i[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_en) bit_q <= bit_d;
      end
      assign flag_o[i] = bit_q;
    end else begin : g_none
      logic unused_in;
      assign unused_in = set_i[i] ^ clr_i[i];
      assign flag_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/pmic_irq_lock.sv
module pmic_irq_lock #(
  parameter int unsigned N_REG = 4,
  parameter int unsigned N_GPO = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_i,
  input  logic             block_i,
  input  logic             force_low_i,
  input  logic [N_REG-1:0] on_req_i,
  input  logic [N_REG-1:0] off_req_i,
  input  logic [N_GPO-1:0] gpo_req_i,
  output logic [N_REG-1:0] reg_en_o,
  output logic [N_GPO-1:0] gpo_o
);

  logic [N_REG-1:0] on_q, on_d;
  logic             on_en;

  always_comb begin
    if (kill_i) on_d = '0;
    else        on_d = (on_q | (on_req_i & {N_REG{~block_i}})) & ~off_req_i;
    on_en = kill_i | (|on_req_i) | (|off_req_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     on_q <= '0;
    else if (on_en) on_q <= on_d;
  end

  assign reg_en_o = on_q;
  assign gpo_o    = gpo_req_i & {N_GPO{~force_low_i}};

endmodule

// File: rtl/pmic_irq_top.sv
module pmic_irq_top
  import pmic_irq_pkg::*;
#(
  parameter int unsigned    AW       = 8,
  parameter logic [AW-1:0]  REG_ADDR = 8'h19,
  parameter int unsigned    N_REG    = 4,
  parameter int unsigned    N_GPO    = 2,
  parameter int unsigned    SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             pg_in,
  input  logic             ext_clk_det_in,
  input  logic             tsd_in,
  input  logic             twarn_in,
  input  logic             ovp_in,
  input  logic             meas_done_i,
  input  logic [DW-1:0]    ldo_pend_i,
  input  logic [DW-1:0]    buck_pend_i,
  input  logic [N_REG-1:0] reg_on_req_i,
  input  logic [N_REG-1:0] reg_off_req_i,
  input  logic [N_GPO-1:0] gpo_req_i,
  output logic [N_REG-1:0] reg_en_o,
  output logic [N_GPO-1:0] gpo_o,
  output logic             irq_o,
  output logic             tsd_live_o,
  output logic             twarn_live_o,
  output logic             ovp_live_o
);

  logic [N_DET-1:0] det_raw, det_lvl, det_rise, det_fall;
  logic [DW-1:0]    set_vec, clr_vec, sticky, reg_val;
  logic             wr_hit, irq_q, irq_d;

  always_comb begin
    det_raw          = '0;
    det_raw[S_PG]    = pg_in;
    det_raw[S_CLK]   = ext_clk_det_in;
    det_raw[S_TSD]   = tsd_in;
    det_raw[S_TWARN] = twarn_in;
    det_raw[S_OVP]   = ovp_in;
  end

  pmic_irq_sync #(.W(N_DET), .STAGES(SYNC_LEN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (det_raw),
    .level_o  (det_lvl),
    .rise_o   (det_rise),
    .fall_o   (det_fall)
  );

  assign wr_hit  = bus_wr && (bus_addr == REG_ADDR);
  assign clr_vec = wr_hit ? bus_wdata : '0;

  always_comb begin
    set_vec          = '0;
    set_vec[B_PG]    = det_fall[S_PG];
    set_vec[B_CLK]   = det_rise[S_CLK] | det_fall[S_CLK];
    set_vec[B_TSD]   = det_rise[S_TSD];
    set_vec[B_TWARN] = det_rise[S_TWARN];
    set_vec[B_OVP]   = det_rise[S_OVP];
    set_vec[B_MEAS]  = meas_done_i;
  end

  pmic_irq_flags #(.W(DW), .MASK(STICKY_MASK)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (sticky)
  );

  always_comb begin
    reg_val         = sticky;
    reg_val[B_LDO]  = |ldo_pend_i;
    reg_val[B_BUCK] = |buck_pend_i;
  end

  assign bus_rdata = (bus_addr == REG_ADDR) ? reg_val : '0;

  assign irq_d = |reg_val;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  pmic_irq_lock #(.N_REG(N_REG), .N_GPO(N_GPO)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .kill_i      (set_vec[B_TSD] | set_vec[B_OVP]),
    .block_i     (sticky[B_TSD]),
    .force_low_i (sticky[B_TSD] | sticky[B_OVP]),
    .on_req_i    (reg_on_req_i),
    .off_req_i   (reg_off_req_i),
    .gpo_req_i   (gpo_req_i),
    .reg_en_o    (reg_en_o),
    .gpo_o       (gpo_o)
  );

  assign tsd_live_o   = det_lvl[S_TSD];
  assign twarn_live_o = det_lvl[S_TWARN];
  assign ovp_live_o   = det_lvl[S_OVP];

endmodule

// File: rtl/pmic_irq_chk.sv
module pmic_irq_chk
  import pmic_irq_pkg::*;
#(
  parameter int unsigned    AW       = 8,
  parameter logic [AW-1:0]  REG_ADDR = 8'h19,
  parameter int unsigned    N_REG    = 4,
  parameter int unsigned    N_GPO    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             meas_done_i,
  input logic [DW-1:0]    ldo_pend_i,
  input logic [DW-1:0]    buck_pend_i,
  input logic [DW-1:0]    reg_val,
  input logic [N_REG-1:0] reg_en_o,
  input logic [N_GPO-1:0] gpo_o,
  input logic             irq_o
);

  // R9
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|reg_val));

  // R8
  ldo_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_ADDR) |-> (bus_rdata[B_LDO] == (|ldo_pend_i)));

  // R8
  buck_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_ADDR) |-> (bus_rdata[B_BUCK] == (|buck_pend_i)));

  // R2
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != REG_ADDR) |-> (bus_rdata == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_ADDR && bus_wdata[B_MEAS] && meas_done_i)
    |=> reg_val[B_MEAS]);

  // R10
  gpo_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_val[B_TSD] || reg_val[B_OVP]) |-> (gpo_o == '0));

  // R10
  fault_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reg_val[B_TSD]) || $rose(reg_val[B_OVP])) |-> (reg_en_o == '0));

  // R11
  tsd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_val[B_TSD]) |-> (reg_en_o == '0));

  // R3
  for (genvar i = 0; i < DW; i++) begin : g_w1c
    if (STICKY_MASK[i]) begin : g_on
      sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_val[i]) |-> $past(bus_wr && bus_addr == REG_ADDR && bus_wdata[i]));
    end
  end

endmodule

bind pmic_irq_top pmic_irq_chk #(
  .AW(AW), .REG_ADDR(REG_ADDR), .N_REG(N_REG), .N_GPO(N_GPO)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .meas_done_i (meas_done_i),
  .ldo_pend_i  (ldo_pend_i),
  .buck_pend_i (buck_pend_i),
  .reg_val     (reg_val),
  .reg_en_o    (reg_en_o),
  .gpo_o       (gpo_o),
  .irq_o       (irq_o)
);

// File: tb/sim_pmic_irq_top.sv
`timescale 1ns/1ps
module sim_pmic_irq_top;

  localparam logic [7:0] RA = 8'h19;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_wr;
  logic       pg_in, ext_clk_det_in, tsd_in, twarn_in, ovp_in, meas_done_i;
  logic [7:0] ldo_pend_i, buck_pend_i;
  logic [3:0] reg_on_req_i, reg_off_req_i, reg_en_o;
  logic [1:0] gpo_req_i, gpo_o;
  logic       irq_o, tsd_live_o, twarn_live_o, ovp_live_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmic_irq_top u0 (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(output logic [7:0] v, input logic [7:0] a = RA);
    bus_addr = a;
    #1;
    v = bus_rdata;
    bus_addr = RA;
  endtask

  task automatic wr(logic [7:0] d, logic [7:0] a = RA);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0; bus_addr = RA;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(v);
    chk("R1", "reg after reset", v, 8'h00);
    chk("R1", "irq after reset", irq_o, 1'b0);
    chk("R1", "reg_en after reset", reg_en_o, 4'h0);
  endtask

  task automatic t_pg;
    logic [7:0] v;
    pg_in = 1'b0;
    step(2);
    rd(v); chk("R13", "pg flag after 2 edges", v[7], 1'b0);
    step(1);
    rd(v); chk("R13", "pg flag after 3 edges", v[7], 1'b1);
    chk("R9", "irq same cycle as flag", irq_o, 1'b0);
    step(1);
    chk("R9", "irq one cycle later", irq_o, 1'b1);
    wr(8'h80);
    rd(v); chk("R3", "pg flag cleared", v, 8'h00);
    step(1);
    chk("R9", "irq drops", irq_o, 1'b0);
    pg_in = 1'b1;
    step(4);
    rd(v); chk("R5", "pg recovery not latched", v, 8'h00);
  endtask

  task automatic t_clkdet;
    logic [7:0] v;
    ext_clk_det_in = 1'b1;
    step(3);
    rd(v); chk("R6", "clock appears", v, 8'h10);
    wr(8'h10);
    ext_clk_det_in = 1'b0;
    step(3);
    rd(v); chk("R6", "clock disappears", v, 8'h10);
    wr(8'h10);
    rd(v); chk("R3", "clk flag cleared", v, 8'h00);
  endtask

  task automatic t_w1c;
    logic [7:0] v;
    meas_done_i = 1'b1; twarn_in = 1'b1;
    step(1);
    meas_done_i = 1'b0;
    step(1);
    chk("R7", "twarn live after 2 edges", twarn_live_o, 1'b1);
    step(1);
    rd(v); chk("R12", "meas and warn flags", v, 8'h05);
    wr(8'h00);
    rd(v); chk("R3", "write 0 keeps bits", v, 8'h05);
    wr(8'h01);
    rd(v); chk("R3", "clear only bit0", v, 8'h04);
    wr(8'hFF);
    rd(v); chk("R3", "clear all", v, 8'h00);
    twarn_in = 1'b0;
    step(3);
    rd(v); chk("R7", "warn fall not latched", v, 8'h00);
    chk("R7", "twarn live follows", twarn_live_o, 1'b0);
  endtask

  task automatic t_setwins;
    logic [7:0] v;
    bus_addr = RA; bus_wdata = 8'h01; bus_wr = 1'b1; meas_done_i = 1'b1;
    step(1);
    bus_wr = 1'b0; meas_done_i = 1'b0;
    rd(v); chk("R4", "set beats clear", v[0], 1'b1);
    wr(8'h01);
    rd(v); chk("R4", "later clear works", v, 8'h00);
  endtask

  task automatic t_summary;
    logic [7:0] v;
    ldo_pend_i = 8'h10;
    rd(v); chk("R8", "ldo summary", v, 8'h40);
    wr(8'h60);
    rd(v); chk("R8", "summary ignores write", v, 8'h40);
    buck_pend_i = 8'h01;
    rd(v); chk("R8", "both summaries", v, 8'h60);
    ldo_pend_i = 8'h00;
    rd(v); chk("R8", "ldo cleared", v, 8'h20);
    buck_pend_i = 8'h00;
    rd(v); chk("R8", "buck cleared", v, 8'h00);
    meas_done_i = 1'b1; step(1); meas_done_i = 1'b0;
    wr(8'hFF, 8'h18);
    rd(v); chk("R2", "foreign write ignored", v, 8'h01);
    rd(v, 8'h18); chk("R2", "foreign read zero", v, 8'h00);
    wr(8'h01);
  endtask

  task automatic t_fault;
    logic [7:0] v;
    gpo_req_i = 2'b11;
    reg_on_req_i = 4'hF; step(1); reg_on_req_i = 4'h0;
    chk("R10", "regulators on", reg_en_o, 4'hF);
    chk("R10", "gpo follows", gpo_o, 2'b11);
    ovp_in = 1'b1;
    step(2);
    chk("R7", "ovp live", ovp_live_o, 1'b1);
    chk("R10", "enables before latch", reg_en_o, 4'hF);
    step(1);
    rd(v); chk("R10", "ovp flag", v, 8'h02);
    chk("R10", "ovp kills enables", reg_en_o, 4'h0);
    chk("R10", "ovp forces gpo", gpo_o, 2'b00);
    reg_on_req_i = 4'h3; step(1); reg_on_req_i = 4'h0;
    chk("R11", "ovp does not block", reg_en_o, 4'h3);
    wr(8'h02);
    chk("R10", "gpo released", gpo_o, 2'b11);
    ovp_in = 1'b0;
    step(3);
    tsd_in = 1'b1;
    step(2);
    chk("R7", "tsd live", tsd_live_o, 1'b1);
    step(1);
    rd(v); chk("R10", "tsd flag", v, 8'h08);
    chk("R10", "tsd kills enables", reg_en_o, 4'h0);
    chk("R10", "tsd forces gpo", gpo_o, 2'b00);
    reg_on_req_i = 4'hF; step(1); reg_on_req_i = 4'h0;
    chk("R11", "tsd blocks enable", reg_en_o, 4'h0);
    wr(8'h08);
    reg_on_req_i = 4'h1; step(1); reg_on_req_i = 4'h0;
    chk("R11", "enable after tsd clear", reg_en_o, 4'h1);
    reg_off_req_i = 4'h1; step(1); reg_off_req_i = 4'h0;
    chk("R11", "disable request", reg_en_o, 4'h0);
    tsd_in = 1'b0;
    step(3);
    rd(v); chk("R7", "tsd fall not latched", v, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = RA; bus_wdata = '0; bus_wr = 1'b0;
    pg_in = 1'b1; ext_clk_det_in = 1'b0; tsd_in = 1'b0; twarn_in = 1'b0;
    ovp_in = 1'b0; meas_done_i = 1'b0; ldo_pend_i = '0; buck_pend_i = '0;
    reg_on_req_i = '0; reg_off_req_i = '0; gpo_req_i = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_pg();
    t_clkdet();
    t_w1c();
    t_setwins();
    t_summary();
    t_fault();
    step(1);
    chk("R9", "irq idle at end", irq_o, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule